// File: doc/BRIEF.md
# Edge-Cleared Watchdog Timer

This block watches a processor's activity through a single strobe line. Every change of the strobe level, whether it rises or falls, counts as a sign of life and restarts an internal cycle counter. If the counter reaches its terminal count before any further activity, the active-low fault output `wdo_n_o` drops. It then stays low until the counter is cleared again. The timeout is a cycle-count parameter. For a nominal 1.6 s period, allowed between 1.0 s and 2.25 s, set it to the clock rate multiplied by the chosen time.

The counter is held at zero while the system is in reset and while the strobe line is flagged as undriven. A floating strobe therefore disables the watchdog entirely. Independently of the counter, a low supply-good flag pulls the output low at once, and the output returns high in the same cycle the supply recovers. This lets the output serve as a low-line indicator when the strobe is left floating. The strobe is synchronised on entry, so the clock must be fast enough that even the shortest strobe pulse the system uses (50 ns) spans at least one clock period.

Top module: `strobe_watchdog`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls with the supply good, `wdo_n_o` is 1.
- R2: With the supply good, no reset, no float and no strobe activity, `wdo_n_o` falls after the T-th rising clock edge following the clearing edge, where T = `TIMEOUT_CYCLES`. It does not fall earlier.
- R3: A rising strobe transition clears the counter and releases an expired output.
- R4: A falling strobe transition clears the counter and releases an expired output.
- R5: While `sys_reset_i` is 1, the counter is held at zero and `wdo_n_o` does not fall for timeout reasons, however long the hold lasts.
- R6: While `strobe_float_i` is 1, the counter is held at zero and strobe level changes have no effect on the output.
- R7: Once expired, the counter saturates at T and does not wrap, so `wdo_n_o` stays low until a clearing cause appears.
- R8: `supply_ok_i` = 0 forces `wdo_n_o` to 0 combinationally, in the same cycle, whether or not a timeout has occurred.
- R9: When `supply_ok_i` returns to 1 and the counter has not expired, `wdo_n_o` is 1 in that same cycle, with no hold delay.
- R10: A strobe level change on the clock edge n clears the counter on edge n + `SYNC_STAGES` + 1. A pulse one clock wide produces two clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block's flops |
| strobe_i | input | 1 | Watchdog strobe level from the processor |
| strobe_float_i | input | 1 | 1 when the strobe line is undriven (tri-stated) |
| sys_reset_i | input | 1 | 1 while the system reset is asserted |
| supply_ok_i | input | 1 | 1 when the supply is above threshold |
| wdo_n_o | output | 1 | Active-low watchdog fault / low-supply output |

## Verification
The bench counts the cycles from the last clearing cause to the fall of the output exactly. An off-by-one terminal compare or a missing synchroniser stage therefore shows up as an output that falls one cycle early or late. Falling-only or rising-only edge detection leaves the output low after the opposite transition. A counter that wraps instead of saturating releases the output by itself after a long idle stretch. If the supply path is registered, the forced-low or recovery value appears one cycle late. A float or system-reset hold that lets the counter creep upward expires during a long hold.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    // Two views of the synchronised strobe used for transition detection
    typedef struct packed {
        logic level;
        logic prev;
    } strobe_view_t;

    // Why the counter is held at zero this cycle (priority order)
    typedef enum logic [1:0] {
        HOLD_NONE  = 2'd0,
        HOLD_SYS   = 2'd1,
        HOLD_FLOAT = 2'd2,
        HOLD_EDGE  = 2'd3
    } hold_cause_e;

    function automatic int cnt_bits(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/wdg_edge_sense.sv
module wdg_edge_sense
    import wdg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    output logic activity_o
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain;
    strobe_view_t           view;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= strobe_i;
    end

    generate
        for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain[LAST];
    end

    always_comb begin
        view.level = chain[LAST];
        view.prev  = prev_q;
        activity_o = view.level ^ view.prev;
    end

endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
    import wdg_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 1000,
    parameter int CNT_W          = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sys_reset_i,
    input  logic             float_i,
    input  logic             activity_i,
    output logic             expired_o,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] TERM = CNT_W'(TIMEOUT_CYCLES);

    hold_cause_e cause;

    always_comb begin
        if (sys_reset_i)     cause = HOLD_SYS;
        else if (float_i)    cause = HOLD_FLOAT;
        else if (activity_i) cause = HOLD_EDGE;
        else                 cause = HOLD_NONE;
    end

    assign expired_o = (count_o == TERM);

    always_ff @(posedge clk) begin
        if (rst)                    count_o <= '0;
        else if (cause != HOLD_NONE) count_o <= '0;
        else if (!expired_o)        count_o <= count_o + 1'b1;
    end

endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog
    import wdg_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 1000,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    input  logic strobe_float_i,
    input  logic sys_reset_i,
    input  logic supply_ok_i,
    output logic wdo_n_o
);

    localparam int CNT_W = cnt_bits(TIMEOUT_CYCLES);

    logic             activity;
    logic             expired;
    logic [CNT_W-1:0] count;

    wdg_edge_sense #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
        .clk        (clk),
        .rst        (rst),
        .strobe_i   (strobe_i),
        .activity_o (activity)
    );

    wdg_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES), .CNT_W(CNT_W)) timer_i (
        .clk         (clk),
        .rst         (rst),
        .sys_reset_i (sys_reset_i),
        .float_i     (strobe_float_i),
        .activity_i  (activity),
        .expired_o   (expired),
        .count_o     (count)
    );

    // Supply path is deliberately unregistered: no hold, no delay
    assign wdo_n_o = supply_ok_i & ~expired;

endmodule

// File: rtl/strobe_watchdog_chk.sv
module strobe_watchdog_chk #(
    parameter int TIMEOUT_CYCLES = 1000,
    parameter int CNT_W          = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             sys_reset_i,
    input logic             strobe_float_i,
    input logic             supply_ok_i,
    input logic             wdo_n_o,
    input logic             activity,
    input logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] TERM = CNT_W'(TIMEOUT_CYCLES);

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (count == '0)); // R1

    AST_SUPPLY_LOW: assert property (@(posedge clk) disable iff (rst)
        !supply_ok_i |-> !wdo_n_o); // R8

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!sys_reset_i && !strobe_float_i && !activity && count != TERM)
        |=> (count == CNT_W'($past(count) + 1'b1))); // R2

    AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (activity && !sys_reset_i && !strobe_float_i) |=> (count == '0)); // R3

    AST_SYS_HOLD: assert property (@(posedge clk) disable iff (rst)
        sys_reset_i |=> (count == '0)); // R5

    AST_FLOAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        strobe_float_i |=> (count == '0)); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= TERM); // R7

    AST_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (count == TERM && !sys_reset_i && !strobe_float_i && !activity)
        |=> (count == TERM)); // R7

endmodule

bind strobe_watchdog strobe_watchdog_chk #(
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
    .CNT_W          (CNT_W)
) chk_i (
    .clk            (clk),
    .rst            (rst),
    .sys_reset_i    (sys_reset_i),
    .strobe_float_i (strobe_float_i),
    .supply_ok_i    (supply_ok_i),
    .wdo_n_o        (wdo_n_o),
    .activity       (activity),
    .count          (count)
);

// File: tb/strobe_watchdog_tb_top.sv
module strobe_watchdog_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int T          = 12;
    localparam int S          = 2;
    localparam int MAX_CYC    = 200000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic strobe = 1'b0;
    logic flt = 1'b0;
    logic sysr = 1'b0;
    logic sok = 1'b1;
    logic wdo_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Bench reference: strobe history and idle-cycle count
    logic hist [0:S];
    int   idle = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strobe_watchdog #(.TIMEOUT_CYCLES(T), .SYNC_STAGES(S)) dut_i (
        .clk            (clk),
        .rst            (rst),
        .strobe_i       (strobe),
        .strobe_float_i (flt),
        .sys_reset_i    (sysr),
        .supply_ok_i    (sok),
        .wdo_n_o        (wdo_n)
    );

    function automatic logic expect_out(input logic supply, input int idle_n);
        return supply && (idle_n < T);
    endfunction

    task automatic check(input logic got, input logic exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: wdo_n_o=%0b expected=%0b at %0t", tag, got, exp, $time);
        end
    endtask

    // Called at a posedge: activity seen at this edge is the change of the
    // strobe sampled S and S+1 edges ago (R10)
    task automatic model_edge();
        if (rst) begin
            for (int i = 0; i <= S; i++) hist[i] = 1'b0;
            idle = 0;
        end else begin
            if (sysr || flt || (hist[S-1] != hist[S])) idle = 0;
            else if (idle < T) idle++;
            for (int i = S; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = strobe;
        end
    endtask

    // Drive at negedge, check away from edge, then advance one clock
    task automatic step(input logic s, input logic f, input logic sr,
                        input logic ok, input string tag);
        strobe = s; flt = f; sysr = sr; sok = ok;
        #1;
        if (!done) check(wdo_n, rst ? ok : expect_out(ok, idle), tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic hold(input int n, input string tag);
        for (int i = 0; i < n; i++) step(strobe, flt, sysr, sok, tag);
    endtask

    initial begin
        for (int i = 0; i <= S; i++) hist[i] = 1'b0;
        void'($urandom(32'h5EED_0706));
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 1'b1, "R1");
        rst = 1'b0;
        step(1'b0, 1'b0, 1'b0, 1'b1, "R1");

        // R2: idle timeout, exact cycle
        hold(T + 4, "R2");
        check(wdo_n, 1'b0, "R2");
        // R7: stays low, no wrap
        hold(3 * T, "R7");
        check(wdo_n, 1'b0, "R7");
        // R3: rising transition releases
        step(1'b1, 1'b0, 1'b0, 1'b1, "R3");
        hold(S + 2, "R3");
        check(wdo_n, 1'b1, "R3");
        hold(T + 2, "R2");
        // R4: falling transition releases
        step(1'b0, 1'b0, 1'b0, 1'b1, "R4");
        hold(S + 2, "R4");
        check(wdo_n, 1'b1, "R4");
        // R5: system reset hold for a long time
        step(1'b0, 1'b0, 1'b1, 1'b1, "R5");
        hold(3 * T, "R5");
        check(wdo_n, 1'b1, "R5");
        step(1'b0, 1'b0, 1'b0, 1'b1, "R5");
        hold(T + 3, "R2");
        // R6: float hold, strobe toggles ignored
        for (int i = 0; i < 3 * T; i++)
            step(logic'($urandom_range(0, 1)), 1'b1, 1'b0, 1'b1, "R6");
        check(wdo_n, 1'b1, "R6");
        step(strobe, 1'b0, 1'b0, 1'b1, "R6");
        hold(T + 4, "R6");
        // R8/R9: supply forcing while expired and while counting
        step(strobe, 1'b0, 1'b0, 1'b0, "R8");
        step(~strobe, 1'b0, 1'b0, 1'b0, "R8");
        hold(S + 2, "R8");
        step(strobe, 1'b0, 1'b0, 1'b1, "R9");
        check(wdo_n, 1'b1, "R9");
        // R10: one-cycle pulse is seen as activity
        hold(T - 2, "R10");
        step(~strobe, 1'b0, 1'b0, 1'b1, "R10");
        step(~strobe, 1'b0, 1'b0, 1'b1, "R10");
        hold(T - 1, "R10");
        check(wdo_n, 1'b1, "R10");
        hold(4, "R10");

        // Constrained random mix
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(0, 99);
            logic s = strobe;
            if (r < 8) s = ~strobe;
            step(s, ($urandom_range(0, 99) < 3), ($urandom_range(0, 99) < 3),
                 ($urandom_range(0, 99) >= 4), "R2");
            if ($urandom_range(0, 99) < 2) hold(T + 2, "R7");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: run hung, got=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule